// File: doc/BRIEF.md
# Universal Shift Register with Shared Parallel Bus

This block is a parameterised storage register (eight bits by default) that can keep its value, move its contents one place toward the high end or toward the low end, or take a full word from a parallel bus. Every change of state takes place on the rising clock edge. A synchronous, active-low clear input has priority over the mode selects. Two mode-select inputs choose the operation. Each shift direction has its own serial data input.

The parallel bus is bidirectional. For synthesis it is split into an input word, an output word and a single active-high drive enable. The register drives the bus only when both active-low enables are low and the load operation is not selected. This leaves the bus free for an external source during a load. The lowest and highest bits also appear on dedicated serial outputs at all times. Two or more instances can therefore be chained into a longer shift path by cross-connecting those outputs with the neighbouring serial inputs.

Top module: `usr_shift_reg`

## Requirements
- R1: The mode is {sel1, sel0}, sampled at the rising clock edge: 2'b00 keeps the value, 2'b01 shifts toward the high end, 2'b10 shifts toward the low end, 2'b11 loads from the bus.
- R2: When clear_n is low at a rising edge, every bit becomes 0 whatever the mode selects are.
- R3: In load mode, bit n takes bus_in[n] at the edge.
- R4: In right-shift mode, bit 0 takes ser_in_right and bit n+1 takes the previous bit n.
- R5: In left-shift mode, bit WIDTH-1 takes ser_in_left and bit n-1 takes the previous bit n.
- R6: In hold mode, the contents do not change.
- R7: bus_oe is low whenever oe1_n or oe2_n is high. Clear, load, shift and hold still update the register while the bus is not driven.
- R8: bus_oe is low whenever both mode selects are high, whatever the enables are. It is high only when both enables are low and the mode is not load.
- R9: ser_out_lo always equals bit 0 and ser_out_hi always equals bit WIDTH-1, whatever the enables are. This lets two instances pass bits between them in both shift directions.
- R10: bus_out always equals the register contents, whether or not bus_oe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on its rising edge |
| clear_n | input | 1 | Synchronous clear, active low, overrides the mode |
| sel1 | input | 1 | Mode select, upper bit |
| sel0 | input | 1 | Mode select, lower bit |
| ser_in_right | input | 1 | Serial data entering bit 0 on a right shift |
| ser_in_left | input | 1 | Serial data entering bit WIDTH-1 on a left shift |
| oe1_n | input | 1 | Bus drive enable, active low |
| oe2_n | input | 1 | Second bus drive enable, active low |
| bus_in | input | WIDTH | Parallel bus value seen at the pins (load data) |
| bus_out | output | WIDTH | Register contents presented to the bus drivers |
| bus_oe | output | 1 | Active-high drive enable for the whole bus |
| ser_out_lo | output | 1 | Bit 0 of the register |
| ser_out_hi | output | 1 | Bit WIDTH-1 of the register |

## Verification
The assertions check the following on every clock against the previous cycle's inputs: the clear result, the load, both shift directions, the hold, and the two conditions that force bus_oe low. Some behaviour can only be shown by the bench's scenarios. These are the serial transfer of bits across a pair of chained instances in both directions, clear taking priority over a simultaneous load, and the register continuing to update while the bus is disabled. Long random sequences of modes, enables and data are compared cycle by cycle against a behavioural model of the chained pair.

// File: rtl/usr_pkg.sv
package usr_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD  = 2'b00,
        MODE_RIGHT = 2'b01,
        MODE_LEFT  = 2'b10,
        MODE_LOAD  = 2'b11
    } usr_mode_e;

    typedef struct packed {
        usr_mode_e mode;
        logic      clear;
        logic      drive;
    } usr_ctrl_t;

    function automatic usr_mode_e usr_decode(input logic s1, input logic s0);
        return usr_mode_e'({s1, s0});
    endfunction

    function automatic logic usr_bus_drive(input logic o1_n, input logic o2_n,
                                           input usr_mode_e m);
        return !o1_n && !o2_n && (m != MODE_LOAD);
    endfunction

endpackage

// File: rtl/usr_ctrl.sv
module usr_ctrl
    import usr_pkg::*;
(
    input  logic      sel1,
    input  logic      sel0,
    input  logic      clear_n,
    input  logic      oe1_n,
    input  logic      oe2_n,
    output usr_ctrl_t ctrl
);
    usr_mode_e mode_w;

    always_comb begin
        mode_w     = usr_decode(sel1, sel0);
        ctrl.mode  = mode_w;
        ctrl.clear = !clear_n;
        ctrl.drive = usr_bus_drive(oe1_n, oe2_n, mode_w);
    end
endmodule

// File: rtl/usr_next.sv
module usr_next
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  usr_ctrl_t          ctrl,
    input  logic [WIDTH-1:0]   cur,
    input  logic [WIDTH-1:0]   load_val,
    input  logic               fill_lo,
    input  logic               fill_hi,
    output logic [WIDTH-1:0]   nxt
);
    localparam int TOP = WIDTH - 1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic from_below;
        logic from_above;

        if (i == 0) begin : g_lo_end
            assign from_below = fill_lo;
        end else begin : g_lo_mid
            assign from_below = cur[i-1];
        end

        if (i == TOP) begin : g_hi_end
            assign from_above = fill_hi;
        end else begin : g_hi_mid
            assign from_above = cur[i+1];
        end

        always_comb begin
            if (ctrl.clear) begin
                nxt[i] = 1'b0;
            end else begin
                unique case (ctrl.mode)
                    MODE_HOLD:  nxt[i] = cur[i];
                    MODE_RIGHT: nxt[i] = from_below;
                    MODE_LEFT:  nxt[i] = from_above;
                    MODE_LOAD:  nxt[i] = load_val[i];
                    default:    nxt[i] = cur[i];
                endcase
            end
        end
    end
endmodule

// File: rtl/usr_store.sv
module usr_store #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        q <= d;
    end
endmodule

// File: rtl/usr_shift_reg.sv
module usr_shift_reg
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clear_n,
    input  logic             sel1,
    input  logic             sel0,
    input  logic             ser_in_right,
    input  logic             ser_in_left,
    input  logic             oe1_n,
    input  logic             oe2_n,
    input  logic [WIDTH-1:0] bus_in,
    output logic [WIDTH-1:0] bus_out,
    output logic             bus_oe,
    output logic             ser_out_lo,
    output logic             ser_out_hi
);
    localparam int TOP = WIDTH - 1;

    usr_ctrl_t        ctrl;
    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_d;

    usr_ctrl u_ctrl (
        .sel1    (sel1),
        .sel0    (sel0),
        .clear_n (clear_n),
        .oe1_n   (oe1_n),
        .oe2_n   (oe2_n),
        .ctrl    (ctrl)
    );

    usr_next #(.WIDTH(WIDTH)) u_next (
        .ctrl     (ctrl),
        .cur      (state_q),
        .load_val (bus_in),
        .fill_lo  (ser_in_right),
        .fill_hi  (ser_in_left),
        .nxt      (state_d)
    );

    usr_store #(.WIDTH(WIDTH)) u_store (
        .clk (clk),
        .d   (state_d),
        .q   (state_q)
    );

    assign bus_out    = state_q;
    assign bus_oe     = ctrl.drive;
    assign ser_out_lo = state_q[0];
    assign ser_out_hi = state_q[TOP];

    // Clear wins over any mode (R2)
    assert_clear_wins_R2: assert property (@(posedge clk)
        !clear_n |=> (bus_out == '0));

    assert_load_takes_bus_R3: assert property (@(posedge clk) disable iff (!clear_n)
        (sel1 && sel0) |=> (bus_out == $past(bus_in)));

    assert_shift_right_R4: assert property (@(posedge clk) disable iff (!clear_n)
        (!sel1 && sel0) |=> (bus_out == {$past(bus_out[TOP-1:0]), $past(ser_in_right)}));

    assert_shift_left_R5: assert property (@(posedge clk) disable iff (!clear_n)
        (sel1 && !sel0) |=> (bus_out == {$past(ser_in_left), $past(bus_out[TOP:1])}));

    assert_hold_keeps_R6: assert property (@(posedge clk) disable iff (!clear_n)
        (!sel1 && !sel0) |=> $stable(bus_out));

    assert_enable_pins_R7: assert property (@(posedge clk)
        (oe1_n || oe2_n) |-> !bus_oe);

    assert_load_releases_bus_R8: assert property (@(posedge clk)
        (sel1 && sel0) |-> !bus_oe);
endmodule

// File: tb/test_usr_shift_reg.sv
module test_usr_shift_reg;
    localparam int W = 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic clear_n = 1'b0, sel1 = 1'b0, sel0 = 1'b0;
    logic sir = 1'b0, sil = 1'b0, o1 = 1'b0, o2 = 1'b0;
    logic [W-1:0] bin_a = '0, bin_b = '0;
    logic [W-1:0] out_a, out_b;
    logic oe_a, oe_b, lo_a, hi_a, lo_b, hi_b;

    usr_shift_reg #(.WIDTH(W)) i_usr_shift_reg (
        .clk(clk), .clear_n(clear_n), .sel1(sel1), .sel0(sel0),
        .ser_in_right(sir), .ser_in_left(lo_b), .oe1_n(o1), .oe2_n(o2),
        .bus_in(bin_a), .bus_out(out_a), .bus_oe(oe_a),
        .ser_out_lo(lo_a), .ser_out_hi(hi_a));

    usr_shift_reg #(.WIDTH(W)) i_usr_shift_reg_hi (
        .clk(clk), .clear_n(clear_n), .sel1(sel1), .sel0(sel0),
        .ser_in_right(hi_a), .ser_in_left(sil), .oe1_n(o1), .oe2_n(o2),
        .bus_in(bin_b), .bus_out(out_b), .bus_oe(oe_b),
        .ser_out_lo(lo_b), .ser_out_hi(hi_b));

    int checks = 0;
    int errors = 0;
    bit [W-1:0] ra = '0, rb = '0;
    string lbl;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock: drive at a falling edge, model the rising edge, compare at the next falling edge
    task automatic cycle(input bit c_n, input bit s1, input bit s0, input bit r_in,
                         input bit l_in, input bit e1, input bit e2,
                         input bit [W-1:0] da, input bit [W-1:0] db);
        bit exp_oe;
        bit [W-1:0] na, nb;
        clear_n = c_n; sel1 = s1; sel0 = s0; sir = r_in; sil = l_in;
        o1 = e1; o2 = e2; bin_a = da; bin_b = db;
        #1;
        exp_oe = !e1 && !e2 && !(s1 && s0);
        chk(oe_a == exp_oe && oe_b == exp_oe, (s1 && s0) ? "R8" : "R7",
            int'(oe_a), int'(exp_oe));
        // R1: mode is {sel1, sel0}
        na = ra; nb = rb;
        if (!c_n) begin
            na = '0; nb = '0; lbl = "R2";
        end else begin
            case ({s1, s0})
                2'b11: begin na = da; nb = db; lbl = "R1/R3"; end
                2'b01: begin na = {ra[W-2:0], r_in}; nb = {rb[W-2:0], ra[W-1]}; lbl = "R1/R4"; end
                2'b10: begin na = {rb[0], ra[W-1:1]}; nb = {l_in, rb[W-1:1]}; lbl = "R1/R5"; end
                default: lbl = "R1/R6";
            endcase
        end
        if (!exp_oe) lbl = {lbl, "/R10"};
        ra = na; rb = nb;
        @(negedge clk);
        chk(out_a == ra, lbl, int'(out_a), int'(ra));
        chk(out_b == rb, lbl, int'(out_b), int'(rb));
        chk({hi_b, lo_b, hi_a, lo_a} == {rb[W-1], rb[0], ra[W-1], ra[0]}, "R9",
            int'({hi_b, lo_b, hi_a, lo_a}), int'({rb[W-1], rb[0], ra[W-1], ra[0]}));
    endtask

    bit done = 1'b0;

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cycle(0, 0, 0, 0, 0, 0, 0, 8'h00, 8'h00);   // R2 clear from power-up
        cycle(1, 1, 1, 0, 0, 0, 0, 8'hA5, 8'h3C);   // R3 load, R8 bus released
        cycle(1, 0, 0, 1, 1, 0, 0, 8'hFF, 8'hFF);   // R6 hold, R7 driven
        cycle(1, 0, 0, 0, 0, 1, 0, 8'h00, 8'h00);   // R7 disabled, R10 contents still out
        cycle(1, 0, 1, 1, 0, 0, 1, 8'h00, 8'h00);   // R4 shift while disabled (R7)
        cycle(1, 1, 0, 0, 1, 1, 1, 8'h00, 8'h00);   // R5 shift left
        cycle(0, 1, 1, 0, 0, 0, 0, 8'hFF, 8'hFF);   // R2 beats load
        cycle(1, 1, 1, 0, 0, 1, 1, 8'h80, 8'h00);   // R8 with enables off
        cycle(1, 0, 1, 0, 0, 0, 0, 8'h00, 8'h00);   // R9 bit crosses into upper instance
        chk(out_b == 8'h01, "R9", int'(out_b), 8'h01);
        cycle(1, 1, 0, 0, 0, 0, 0, 8'h00, 8'h00);   // R9 back across, left
        chk(out_a == 8'h80, "R9", int'(out_a), 8'h80);
        for (int k = 0; k < 2000; k++) begin
            cycle(($urandom % 16) != 0, 1'($urandom), 1'($urandom), 1'($urandom),
                  1'($urandom), ($urandom % 4) == 0, ($urandom % 4) == 0,
                  8'($urandom), 8'($urandom));
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule